// File: doc/BRIEF.md
# Addressed Serial Configuration Port

This block is a three-wire serial slave that loads a bank of byte-wide configuration registers. A host shifts in 16-bit frames, most significant bit first: the first eight bits name a register and the last eight carry the value. All three serial lines (bit clock, data and an active-low frame enable) are oversampled by the master clock. A data bit is taken on each rising edge of the serial bit clock while the frame enable is low.

Once the sixteenth bit has been taken, the frame is parked in a hold register. A short countdown then places the value into the addressed register at a fixed number of master clocks after that last bit clock rise. Only addresses inside a 16-entry window starting at 0xF0 are decoded. Each register keeps only its implemented bits, and every register returns to a fixed default on clear. The whole register bank is presented as one flat output bus, so downstream timing logic can decode the fields it needs.

Top module: `scfg_port`

## Requirements
- R1: While `clrN` is low, every register holds its default, listed by offset from 0xF0 as offset=value: 0=0x05, 1=0x3F, 2=0x44, 3=0x23, 4=0x00, 5=0x04, 6=0x30, 7=0x00, 8=0x00, 9=0x80, 10=0x1D, 11=0x3F, 12=0x00, 13=0x00, 14=0x00, 15=0x80. Register at offset k occupies `regFile[8k+7:8k]`. The defaults hold again after any later clear.
- R2: A frame is 16 bits sent most significant bit first, each bit taken from `sdat` on a rising edge of `sclk`. The first 8 bits form the address and the last 8 form the data.
- R3: A complete frame changes the addressed register at the 10th rising master-clock edge after the first edge that samples `sclk` high for the 16th bit. The register is unchanged one cycle earlier, and no other register changes.
- R4: Frames are accepted only while `sctlN` is low. Raising `sctlN` before the 16th bit discards the partial frame without any register change, and `sclk` edges while `sctlN` is high shift nothing. The next frame then starts aligned at its first bit.
- R5: A frame whose address lies outside 0xF0 to 0xFF (for example 0xEF or 0x3A) changes no register.
- R6: Only implemented bits are written; the others read 0. Writable masks by offset: 0=0x07, 4=0x1F, 5=0x3F, 6=0x3F, 8=0x07, 10=0x1F, 12=0x07, 14=0x07, and 0xFF for all other offsets.
- R7: Two frames sent back to back with `sctlN` held low across both are each committed, in order, with the R3 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| clrN | input | 1 | Asynchronous clear, active low |
| sclk | input | 1 | Serial bit clock from the host |
| sdat | input | 1 | Serial data from the host |
| sctlN | input | 1 | Frame enable, active low |
| regFile | output | NUM_REGS*DATA_W (128) | All registers, offset k at bits [8k+7:8k] |

## Verification
The bench builds the port with its default parameters: a 16-entry window based at 0xF0, a two-stage input synchronizer and a 10-cycle commit delay. With these values both window edges (0xF0 and 0xFF) can be hit, and the nearest outside address (0xEF) can be sent. The exact commit cycle can be checked one cycle before and at the write. Every register with a partial mask can be driven with all-ones data. A scoreboard keeps a model of the whole bank and compares all sixteen registers at each expected commit point, so a stray write anywhere is seen.

// File: rtl/scfg_pkg.sv
package scfg_pkg;

  // Strobes handed from the control path to the datapath each cycle.
  typedef struct packed {
    logic shiftEn;     // take one serial bit
    logic bitIn;       // the synchronized data bit
    logic latchFrame;  // last bit of the frame: park it in the hold register
    logic commit;      // write the parked frame into the register bank
  } scfgStrobe_t;

  // Clear value per register offset.
  function automatic logic [7:0] regDefault(input int idx);
    case (idx)
      0:       return 8'h05;
      1:       return 8'h3F;
      2:       return 8'h44;
      3:       return 8'h23;
      5:       return 8'h04;
      6:       return 8'h30;
      9:       return 8'h80;
      10:      return 8'h1D;
      11:      return 8'h3F;
      15:      return 8'h80;
      default: return 8'h00;
    endcase
  endfunction

  // Implemented-bit mask per register offset.
  function automatic logic [7:0] regMask(input int idx);
    case (idx)
      0, 8, 12, 14: return 8'h07;
      4, 10:        return 8'h1F;
      5, 6:         return 8'h3F;
      default:      return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/scfg_ctrl.sv
module scfg_ctrl
  import scfg_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int FRAME_BITS   = 16,
  parameter int COMMIT_DELAY = 10
) (
  input  logic        clk,
  input  logic        clrN,
  input  logic        sclkIn,
  input  logic        sdatIn,
  input  logic        sctlIn,
  output scfgStrobe_t strobe
);

  localparam int CNT_W  = $clog2(FRAME_BITS);
  // The synchronizer and the edge register account for the remaining cycles.
  localparam int WAIT   = COMMIT_DELAY - SYNC_STAGES - 1;
  localparam int WAIT_W = (WAIT > 1) ? $clog2(WAIT + 1) : 1;

  logic [SYNC_STAGES-1:0] sclkSync, sdatSync, sctlSync;
  logic                   sclkPrev;
  logic [CNT_W-1:0]       bitCnt;
  logic                   pendingQ;
  logic [WAIT_W-1:0]      waitCnt;

  logic sclkLvl, sctlHigh, sclkRise, lastBit;

  // Oversampling synchronizers
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      sclkSync <= '0;
      sdatSync <= '0;
      sctlSync <= '1;
      sclkPrev <= 1'b0;
    end else begin
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclkIn};
      sdatSync <= {sdatSync[SYNC_STAGES-2:0], sdatIn};
      sctlSync <= {sctlSync[SYNC_STAGES-2:0], sctlIn};
      sclkPrev <= sclkLvl;
    end
  end

  assign sclkLvl  = sclkSync[SYNC_STAGES-1];
  assign sctlHigh = sctlSync[SYNC_STAGES-1];
  assign sclkRise = sclkLvl & ~sclkPrev;
  assign lastBit  = (bitCnt == CNT_W'(FRAME_BITS - 1));

  always_comb begin
    strobe.shiftEn    = sclkRise & ~sctlHigh;
    strobe.bitIn      = sdatSync[SYNC_STAGES-1];
    strobe.latchFrame = sclkRise & ~sctlHigh & lastBit;
    strobe.commit     = pendingQ & (waitCnt == '0);
  end

  // Bit position within the frame
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      bitCnt <= '0;
    end else if (sctlHigh) begin
      bitCnt <= '0;
    end else if (strobe.shiftEn) begin
      bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end

  // Fixed-latency countdown from the last bit to the register write
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      pendingQ <= 1'b0;
      waitCnt  <= '0;
    end else if (strobe.latchFrame) begin
      pendingQ <= 1'b1;
      waitCnt  <= WAIT_W'(WAIT);
    end else if (pendingQ) begin
      if (waitCnt == '0) pendingQ <= 1'b0;
      else               waitCnt  <= waitCnt - 1'b1;
    end
  end

  // R4
  frame_abort_chk: assert property (@(posedge clk) disable iff (!clrN)
    sctlHigh |=> (bitCnt == '0));

  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!clrN)
    (strobe.shiftEn && !lastBit) |=> (bitCnt == $past(bitCnt) + 1'b1));

  // R3
  commit_once_chk: assert property (@(posedge clk) disable iff (!clrN)
    strobe.commit |=> !strobe.commit);

endmodule

// File: rtl/scfg_regs.sv
module scfg_regs
  import scfg_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_REGS  = 16,
  parameter int ADDR_BASE = 240
) (
  input  logic                         clk,
  input  logic                         clrN,
  input  scfgStrobe_t                  strobe,
  output logic [NUM_REGS*DATA_W-1:0]   regFlat
);

  localparam int FRAME_BITS = ADDR_W + DATA_W;

  logic [FRAME_BITS-2:0] shiftQ;
  logic [FRAME_BITS-1:0] holdQ;
  logic [ADDR_W-1:0]     holdAddr;
  logic [DATA_W-1:0]     holdData;
  logic [DATA_W-1:0]     regQ [NUM_REGS];
  int                    offset;
  logic                  hit;

  // Serial-in shift register and frame hold register
  always_ff @(posedge clk or negedge clrN) begin
    if (!clrN) begin
      shiftQ <= '0;
      holdQ  <= '0;
    end else begin
      if (strobe.shiftEn)    shiftQ <= {shiftQ[FRAME_BITS-3:0], strobe.bitIn};
      if (strobe.latchFrame) holdQ  <= {shiftQ, strobe.bitIn};
    end
  end

  assign holdAddr = holdQ[FRAME_BITS-1 -: ADDR_W];
  assign holdData = holdQ[DATA_W-1:0];

  // Window decode
  always_comb begin
    offset = int'(holdAddr) - ADDR_BASE;
    hit    = (offset >= 0) && (offset < NUM_REGS);
  end

  // Register bank
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    localparam logic [DATA_W-1:0] DEF  = DATA_W'(regDefault(i));
    localparam logic [DATA_W-1:0] MASK = DATA_W'(regMask(i));

    always_ff @(posedge clk or negedge clrN) begin
      if (!clrN) begin
        regQ[i] <= DEF;
      end else if (strobe.commit && hit && (offset == i)) begin
        regQ[i] <= holdData & MASK;
      end
    end

    assign regFlat[i*DATA_W +: DATA_W] = regQ[i];

    // R6
    spare_bits_chk: assert property (@(posedge clk) disable iff (!clrN)
      ((regQ[i] & ~MASK) == '0));
  end

  // R3
  quiet_bank_chk: assert property (@(posedge clk) disable iff (!clrN)
    !strobe.commit |=> $stable(regFlat));

  // R5
  miss_addr_chk: assert property (@(posedge clk) disable iff (!clrN)
    (strobe.commit && !hit) |=> $stable(regFlat));

endmodule

// File: rtl/scfg_port.sv
module scfg_port
  import scfg_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int DATA_W       = 8,
  parameter int NUM_REGS     = 16,
  parameter int ADDR_BASE    = 240,
  parameter int SYNC_STAGES  = 2,
  parameter int COMMIT_DELAY = 10
) (
  input  logic                       clk,
  input  logic                       clrN,
  input  logic                       sclk,
  input  logic                       sdat,
  input  logic                       sctlN,
  output logic [NUM_REGS*DATA_W-1:0] regFile
);

  localparam int FRAME_BITS = ADDR_W + DATA_W;

  scfgStrobe_t strobe;

  scfg_ctrl #(
    .SYNC_STAGES (SYNC_STAGES),
    .FRAME_BITS  (FRAME_BITS),
    .COMMIT_DELAY(COMMIT_DELAY)
  ) u_ctrl (
    .clk   (clk),
    .clrN  (clrN),
    .sclkIn(sclk),
    .sdatIn(sdat),
    .sctlIn(sctlN),
    .strobe(strobe)
  );

  scfg_regs #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_BASE(ADDR_BASE)
  ) u_regs (
    .clk    (clk),
    .clrN   (clrN),
    .strobe (strobe),
    .regFlat(regFile)
  );

endmodule

// File: tb/sim_scfg_port.sv
`timescale 1ns/1ps
module sim_scfg_port;

  logic         clk = 1'b0;
  logic         clrN, sclk, sdat, sctlN;
  logic [127:0] regFile;

  int cyc = 0;
  int totalCnt = 0;
  int failCnt = 0;
  bit done = 1'b0;

  logic [7:0] expRegs [16];

  // Scoreboard queues (one entry per expected commit point)
  int         dueQ [$];
  bit         hitQ [$];
  int         idxQ [$];
  logic [7:0] valQ [$];
  string      reqQ [$];

  scfg_port u0 (
    .clk(clk), .clrN(clrN), .sclk(sclk), .sdat(sdat), .sctlN(sctlN),
    .regFile(regFile)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [7:0] defOf(input int i);
    logic [7:0] t [16] = '{8'h05, 8'h3F, 8'h44, 8'h23, 8'h00, 8'h04, 8'h30, 8'h00,
                           8'h00, 8'h80, 8'h1D, 8'h3F, 8'h00, 8'h00, 8'h00, 8'h80};
    return t[i];
  endfunction

  function automatic logic [7:0] maskOf(input int i);
    logic [7:0] t [16] = '{8'h07, 8'hFF, 8'hFF, 8'hFF, 8'h1F, 8'h3F, 8'h3F, 8'hFF,
                           8'h07, 8'hFF, 8'h1F, 8'hFF, 8'h07, 8'hFF, 8'h07, 8'hFF};
    return t[i];
  endfunction

  task automatic checkBank(input string req, input string phase);
    bit bad = 1'b0;
    totalCnt++;
    for (int i = 0; i < 16; i++) begin
      if (!bad && regFile[i*8 +: 8] !== expRegs[i]) begin
        bad = 1'b1;
        failCnt++;
        $display("FAIL %s %s: reg offset %0d actual %02h expected %02h",
                 req, phase, i, regFile[i*8 +: 8], expRegs[i]);
      end
    end
  endtask

  task automatic loadDefaults();
    for (int i = 0; i < 16; i++) expRegs[i] = defOf(i);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  // Monitor: compare the bank one cycle before and at each expected commit
  always @(negedge clk) begin
    if (dueQ.size() > 0) begin
      if (cyc == dueQ[0] - 1) begin
        checkBank(reqQ[0], "before commit");
      end else if (cyc == dueQ[0]) begin
        if (hitQ[0]) expRegs[idxQ[0]] = valQ[0];
        checkBank(reqQ[0], "at commit");
        void'(dueQ.pop_front());
        void'(hitQ.pop_front());
        void'(idxQ.pop_front());
        void'(valQ.pop_front());
        void'(reqQ.pop_front());
      end
    end
  end

  task automatic pushItem(input int due, input logic [7:0] addr,
                          input logic [7:0] data, input string req);
    bit h = (addr >= 8'hF0);
    int k = h ? int'(addr) - 240 : 0;
    dueQ.push_back(due);
    hitQ.push_back(h);
    idxQ.push_back(k);
    valQ.push_back(h ? (data & maskOf(k)) : 8'h00);
    reqQ.push_back(req);
  endtask

  // Shift nbits of a frame, MSB first; returns the cycle of the last rise
  task automatic frameBody(input logic [15:0] f, input int nbits, output int lastCyc);
    lastCyc = 0;
    for (int b = 15; b > 15 - nbits; b--) begin
      sdat = f[b];
      repeat (5) @(negedge clk);
      sclk = 1'b1;
      lastCyc = cyc;
      repeat (5) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  // The write lands 11 counter steps after the cycle in which sclk rose
  task automatic sendFrame(input logic [7:0] addr, input logic [7:0] data,
                           input string req);
    int c;
    sctlN = 1'b0;
    repeat (10) @(negedge clk);
    frameBody({addr, data}, 16, c);
    pushItem(c + 11, addr, data, req);
    repeat (12) @(negedge clk);
    sctlN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic drainQueue();
    while (dueQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      totalCnt++;
      failCnt++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int c;
    clrN = 1'b0; sclk = 1'b0; sdat = 1'b0; sctlN = 1'b1;
    loadDefaults();
    repeat (5) @(negedge clk);
    checkBank("R1", "during clear");
    clrN = 1'b1;
    repeat (3) @(negedge clk);
    checkBank("R1", "after clear");

    // R3 / R2: plain writes, including both window edges
    sendFrame(8'hF2, 8'h5A, "R3");
    sendFrame(8'hF0, 8'h03, "R3");
    sendFrame(8'hFF, 8'hA5, "R3");
    // R2: bit order (0x12 reversed would be 0x48)
    sendFrame(8'hF1, 8'h12, "R2");

    // R6: all-ones into partially implemented registers
    sendFrame(8'hF0, 8'hFF, "R6");
    sendFrame(8'hF5, 8'hFF, "R6");
    sendFrame(8'hFA, 8'hFF, "R6");

    // R5: outside the window
    sendFrame(8'hEF, 8'h11, "R5");
    sendFrame(8'h3A, 8'h77, "R5");

    // R4: abort after 9 bits, then a clean frame must still align
    sctlN = 1'b0;
    repeat (10) @(negedge clk);
    frameBody({8'hF3, 8'hC3}, 9, c);
    repeat (12) @(negedge clk);
    sctlN = 1'b1;
    pushItem(cyc + 12, 8'h00, 8'h00, "R4");
    repeat (20) @(negedge clk);
    sendFrame(8'hF3, 8'hC3, "R4");

    // R4: sclk toggled with the frame disabled shifts nothing
    frameBody({8'hF4, 8'h0F}, 16, c);
    pushItem(cyc + 12, 8'h00, 8'h00, "R4");
    repeat (20) @(negedge clk);
    sendFrame(8'hF8, 8'h06, "R4");

    // R7: two frames under one continuous enable
    sctlN = 1'b0;
    repeat (10) @(negedge clk);
    frameBody({8'hF7, 8'h9C}, 16, c);
    pushItem(c + 11, 8'hF7, 8'h9C, "R7");
    frameBody({8'hF9, 8'h3E}, 16, c);
    pushItem(c + 11, 8'hF9, 8'h3E, "R7");
    repeat (12) @(negedge clk);
    sctlN = 1'b1;
    drainQueue();

    // R1: a later clear restores every default
    clrN = 1'b0;
    repeat (3) @(negedge clk);
    loadDefaults();
    checkBank("R1", "second clear");
    clrN = 1'b1;
    repeat (3) @(negedge clk);
    checkBank("R1", "after second clear");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule